// File: doc/BRIEF.md
# Frame-Synchronous Mode Control Latch

This block sits in front of an echo-cancelling signal processor that runs one processing cycle per 8 kHz frame. Six mode controls (centre clipping, through mode, coefficient freeze, attenuator enable, gain control, howling detection) arrive asynchronously from board pins. The block resynchronises them and latches a copy only at defined instants: on a high-to-low transition of the cycle-start strobe, and once after reset is released. The processor therefore sees one configuration for a whole frame.

After reset the block holds off cycle-start transitions for an initialisation window. This window is 100 ms at a 19.2 MHz master clock by default, and its length is a parameter. The block pulses a processing-start output for each accepted transition, times the processing cycle, and raises a cycle-done level when the cycle completes. From the latched attenuator enable and two channel activity flags, it selects which of the two 6 dB attenuators (receive-input or send-output) is engaged. While power-down is requested, the block ignores all inputs and freezes its state.

Top module: `frame_ctrl_latch`

## Requirements
- R1: After `rst_ni` rises, the six control inputs are captured at the third rising clock edge, with `SYNC_STAGES`=2. Through mode (`thru_en_i`) captured as 1 also raises `coef_clr_o` for exactly that one cycle.
- R2: Between captures, the latched control outputs do not change, whatever the control inputs do.
- R3: A high-to-low transition of `cyc_strobe_i`, first sampled low at rising edge a, produces a one-cycle `proc_start_o` pulse after edge a+2. The control values present with the transition are latched at that same edge.
- R4: A cycle-start transition is ignored (no pulse, no capture) when its acceptance edge falls within the first `INIT_CYCLES` rising edges after reset release.
- R5: `rst_ni` is an active-low asynchronous reset. While it is low, every output is 0.
- R6: With the latched attenuator enable at 1, `att_tx_o` is 1 exactly when `rx_act_i`=1 and `tx_act_i`=0, and otherwise `att_rx_o` is 1, so exactly one is active. With the enable at 0, both are 0.
- R7: `coef_clr_o` pulses for one cycle with each capture whose through-mode value is 1, and it is 0 otherwise.
- R8: `cyc_done_o` falls at the edge that starts a cycle and rises `PROC_CYCLES` edges later. It is held at 0 during reset.
- R9: While `pwr_ni` is low, strobe transitions and control inputs are ignored. The latched controls are unchanged and `cyc_done_o` holds its level, including a cycle in progress, which does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ni | input | 1 | Power-down request, active low (asynchronous) |
| cyc_strobe_i | input | 1 | Cycle-start strobe, falling edge active (asynchronous) |
| clip_en_i | input | 1 | Centre-clip control (asynchronous) |
| thru_en_i | input | 1 | Through-mode control (asynchronous) |
| freeze_en_i | input | 1 | Coefficient-freeze control (asynchronous) |
| att_en_i | input | 1 | Attenuator enable (asynchronous) |
| gain_en_i | input | 1 | Gain-control enable (asynchronous) |
| howl_en_i | input | 1 | Howling-detect enable (asynchronous) |
| rx_act_i | input | 1 | Receive-channel activity flag (synchronous) |
| tx_act_i | input | 1 | Send-channel activity flag (synchronous) |
| clip_o | output | 1 | Latched centre-clip control |
| thru_o | output | 1 | Latched through-mode control |
| freeze_o | output | 1 | Latched coefficient-freeze control |
| att_en_o | output | 1 | Latched attenuator enable |
| gain_o | output | 1 | Latched gain-control enable |
| howl_o | output | 1 | Latched howling-detect enable |
| coef_clr_o | output | 1 | Coefficient clear request pulse |
| att_rx_o | output | 1 | Receive-input 6 dB attenuator engaged |
| att_tx_o | output | 1 | Send-output 6 dB attenuator engaged |
| proc_start_o | output | 1 | Processing-start pulse |
| cyc_done_o | output | 1 | Processing cycle complete level |

## Verification
The bench sweeps the strobe drop across every edge around the end of the initialisation window and requires the first accepted pulse at exactly edge 41. A counter off by one would shift that boundary or let an early strobe through. All 64 control patterns are captured both at reset release and through the strobe, with the inputs changed straight afterwards. A design that captured one edge early would latch reset values, and one that sampled continuously would show the changed inputs. Power-down is applied both with cycle-done high and in the middle of a cycle. A design that kept counting would raise cycle-done, and one that kept capturing would latch the new controls.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  typedef struct packed {
    logic clip;
    logic thru;
    logic freeze;
    logic att_on;
    logic gain;
    logic howl;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/fcl_sync_bank.sv
module fcl_sync_bank #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fcl_init_timer.sv
module fcl_init_timer #(
  parameter int unsigned INIT_CYCLES = 1920000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (en_i && cnt_q != LAST) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign busy_o = (cnt_q != LAST);
endmodule

// File: rtl/fcl_proc_seq.sv
module fcl_proc_seq #(
  parameter int unsigned PROC_CYCLES = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(PROC_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (en_i) begin
      if (start_i) begin
        cnt_q  <= CNT_W'(PROC_CYCLES);
        done_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/fcl_att_sel.sv
module fcl_att_sel (
  input  logic en_i,
  input  logic rx_act_i,
  input  logic tx_act_i,
  output logic att_rx_o,
  output logic att_tx_o
);
  logic rx_only;

  // only-receive talk attenuates send side; all other cases attenuate receive side
  assign rx_only  = rx_act_i & ~tx_act_i;
  assign att_tx_o = en_i & rx_only;
  assign att_rx_o = en_i & ~rx_only;
endmodule

// File: rtl/fcl_mode_latch.sv
module fcl_mode_latch
  import fcl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cap_i,
  input  mode_t mode_i,
  output mode_t mode_o,
  output logic  clr_o
);
  mode_t mode_q;
  logic  clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= cap_i & mode_i.thru;
      if (cap_i) mode_q <= mode_i;
    end
  end

  assign mode_o = mode_q;
  assign clr_o  = clr_q;
endmodule

// File: rtl/frame_ctrl_latch.sv
module frame_ctrl_latch
  import fcl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned INIT_CYCLES = 1920000,
  parameter int unsigned PROC_CYCLES = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ni,
  input  logic cyc_strobe_i,
  input  logic clip_en_i,
  input  logic thru_en_i,
  input  logic freeze_en_i,
  input  logic att_en_i,
  input  logic gain_en_i,
  input  logic howl_en_i,
  input  logic rx_act_i,
  input  logic tx_act_i,
  output logic clip_o,
  output logic thru_o,
  output logic freeze_o,
  output logic att_en_o,
  output logic gain_o,
  output logic howl_o,
  output logic coef_clr_o,
  output logic att_rx_o,
  output logic att_tx_o,
  output logic proc_start_o,
  output logic cyc_done_o
);
  localparam int unsigned BUS_W  = MODE_W + 2;
  localparam int unsigned PEND_W = $clog2(SYNC_STAGES + 2);
  localparam logic [BUS_W-1:0] SYNC_RST = {1'b1, {(BUS_W-1){1'b0}}};

  mode_t            mode_raw, mode_s, mode_q;
  logic [BUS_W-1:0] bus_s;
  logic             pwr_s, strobe_s, strobe_prev_q;
  logic             run_en, strobe_fall, init_busy;
  logic             start_evt, rst_cap, cap_evt;
  logic [PEND_W-1:0] pend_q;
  logic             start_q;

  assign mode_raw = '{clip: clip_en_i, thru: thru_en_i, freeze: freeze_en_i,
                      att_on: att_en_i, gain: gain_en_i, howl: howl_en_i};

  fcl_sync_bank #(
    .W      (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwr_ni, cyc_strobe_i, mode_raw}),
    .q_o   (bus_s)
  );

  assign pwr_s    = bus_s[BUS_W-1];
  assign strobe_s = bus_s[BUS_W-2];
  assign mode_s   = bus_s[MODE_W-1:0];
  assign run_en   = pwr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev_q <= 1'b0;
    else         strobe_prev_q <= strobe_s;
  end

  assign strobe_fall = strobe_prev_q & ~strobe_s;

  // post-reset capture waits until the synchroniser holds real input values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= PEND_W'(SYNC_STAGES + 1);
    else if (run_en && pend_q != '0) pend_q <= pend_q - PEND_W'(1);
  end

  assign rst_cap   = run_en & (pend_q == PEND_W'(1));
  assign start_evt = run_en & strobe_fall & ~init_busy;
  assign cap_evt   = start_evt | rst_cap;

  fcl_init_timer #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_init (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run_en),
    .busy_o(init_busy)
  );

  fcl_mode_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_evt),
    .mode_i(mode_s),
    .mode_o(mode_q),
    .clr_o (coef_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_evt;
  end

  fcl_proc_seq #(
    .PROC_CYCLES(PROC_CYCLES)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_en),
    .start_i(start_evt),
    .done_o (cyc_done_o)
  );

  fcl_att_sel u_att (
    .en_i    (mode_q.att_on),
    .rx_act_i(rx_act_i),
    .tx_act_i(tx_act_i),
    .att_rx_o(att_rx_o),
    .att_tx_o(att_tx_o)
  );

  assign clip_o       = mode_q.clip;
  assign thru_o       = mode_q.thru;
  assign freeze_o     = mode_q.freeze;
  assign att_en_o     = mode_q.att_on;
  assign gain_o       = mode_q.gain;
  assign howl_o       = mode_q.howl;
  assign proc_start_o = start_q;
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_en_i,
  input logic       init_busy_i,
  input logic       cap_evt_i,
  input logic [5:0] mode_i,
  input logic       att_en_i,
  input logic       att_rx_i,
  input logic       att_tx_i,
  input logic       proc_start_i,
  input logic       cyc_done_i,
  input logic       coef_clr_i,
  input logic       thru_i
);
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_i |=> $stable(mode_i)); // R2

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_start_i |=> !proc_start_i); // R3

  AST_NO_START_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_busy_i |=> !proc_start_i); // R4

  AST_ONE_ATT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_en_i |-> $onehot({att_rx_i, att_tx_i})); // R6

  AST_NO_ATT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !att_en_i |-> !att_rx_i && !att_tx_i); // R6

  AST_CLR_NEEDS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_clr_i |-> thru_i); // R7

  AST_DONE_LOW_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_start_i |-> !cyc_done_i); // R8

  AST_PWR_HOLD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> $stable(cyc_done_i)); // R9
endmodule

bind frame_ctrl_latch fcl_checker u_fcl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_en_i    (run_en),
  .init_busy_i (init_busy),
  .cap_evt_i   (cap_evt),
  .mode_i      (mode_q),
  .att_en_i    (att_en_o),
  .att_rx_i    (att_rx_o),
  .att_tx_i    (att_tx_o),
  .proc_start_i(proc_start_o),
  .cyc_done_i  (cyc_done_o),
  .coef_clr_i  (coef_clr_o),
  .thru_i      (thru_o)
);

// File: tb/test_frame_ctrl_latch.sv
module test_frame_ctrl_latch;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_N = 40;
  localparam int PROC_N = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_ni = 1'b1;
  logic cyc_strobe = 1'b1;
  logic [5:0] mode_in = '0;
  logic rx_act = 1'b0, tx_act = 1'b0;
  logic clip_o, thru_o, freeze_o, att_en_o, gain_o, howl_o;
  logic coef_clr_o, att_rx_o, att_tx_o, proc_start_o, cyc_done_o;
  logic [5:0] mode_out;

  int n_chk = 0, n_err = 0, n_start = 0, edge_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_ctrl_latch #(.SYNC_STAGES(2), .INIT_CYCLES(INIT_N), .PROC_CYCLES(PROC_N)) i_frame_ctrl_latch (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ni(pwr_ni), .cyc_strobe_i(cyc_strobe),
    .clip_en_i(mode_in[5]), .thru_en_i(mode_in[4]), .freeze_en_i(mode_in[3]),
    .att_en_i(mode_in[2]), .gain_en_i(mode_in[1]), .howl_en_i(mode_in[0]),
    .rx_act_i(rx_act), .tx_act_i(tx_act),
    .clip_o(clip_o), .thru_o(thru_o), .freeze_o(freeze_o), .att_en_o(att_en_o),
    .gain_o(gain_o), .howl_o(howl_o), .coef_clr_o(coef_clr_o),
    .att_rx_o(att_rx_o), .att_tx_o(att_tx_o),
    .proc_start_o(proc_start_o), .cyc_done_o(cyc_done_o)
  );

  assign mode_out = {clip_o, thru_o, freeze_o, att_en_o, gain_o, howl_o};

  always @(posedge clk) begin
    if (!rst_ni) edge_cnt <= 0;
    else         edge_cnt <= edge_cnt + 1;
  end

  always @(negedge clk) if (proc_start_o) n_start++;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] v);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_in = v;
    cyc_strobe = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // strobe capture of v; returns after acceptance edge + PROC_N
  task automatic strobe_cycle(input logic [5:0] v);
    @(negedge clk);
    mode_in = v;
    cyc_strobe = 1'b0;
    @(negedge clk); check("R3 no pulse at a", proc_start_o, 0);
    @(negedge clk); check("R3 no pulse at a+1", proc_start_o, 0);
    @(negedge clk);
    check("R3 pulse at a+2", proc_start_o, 1);
    check("R3 mode latched", mode_out, v);
    check("R7 clr on strobe capture", coef_clr_o, v[4]);
    check("R8 done low at start", cyc_done_o, 0);
    cyc_strobe = 1'b1;
    mode_in = ~v;
    @(negedge clk);
    check("R3 pulse single", proc_start_o, 0);
    check("R7 clr single", coef_clr_o, 0);
    repeat (4) @(negedge clk);
    check("R8 done low before end", cyc_done_o, 0);
    @(negedge clk);
    check("R8 done high at end", cyc_done_o, 1);
    check("R2 mode held after input change", mode_out, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int s0;
    // R5: outputs low during reset
    mode_in = 6'h3F;
    repeat (3) @(negedge clk);
    check("R5 mode in reset", mode_out, 0);
    check("R5 start in reset", proc_start_o, 0);
    check("R5 done in reset", cyc_done_o, 0);
    check("R5 clr in reset", coef_clr_o, 0);
    check("R5 att in reset", {att_rx_o, att_tx_o}, 0);

    // R1: capture on reset release, all patterns
    for (int v = 0; v < 64; v++) begin
      do_reset(6'(v));
      @(negedge clk); @(negedge clk);
      check("R1 not yet captured at edge 2", mode_out, 0);
      @(negedge clk);
      check("R1 captured at edge 3", mode_out, v);
      check("R7 clr on reset capture", coef_clr_o, (v >> 4) & 1);
      mode_in = ~6'(v);
      @(negedge clk);
      check("R7 clr one cycle", coef_clr_o, 0);
      repeat (5) @(negedge clk);
      check("R2 held without strobe", mode_out, v);
    end

    // R4: sweep strobe drop around end of init window
    for (int m = 30; m <= 45; m++) begin
      int first;
      do_reset(6'h00);
      repeat (m - 1) @(negedge clk);
      cyc_strobe = 1'b0;
      first = -1;
      for (int j = 0; j < 5; j++) begin
        @(negedge clk);
        if (proc_start_o && first < 0) first = edge_cnt;
      end
      cyc_strobe = 1'b1;
      check($sformatf("R4 first start edge, drop before edge %0d", m), first,
            (m + 2 > INIT_N) ? m + 2 : -1);
      repeat (4) @(negedge clk);
    end

    // R3/R8/R2: strobe captures all patterns
    for (int v = 0; v < 64; v++) begin
      strobe_cycle(6'(v));
      repeat (2) @(negedge clk);
    end

    // R6: attenuator selection, enabled (last capture 0x3F)
    for (int k = 0; k < 4; k++) begin
      rx_act = k[1]; tx_act = k[0];
      #1;
      check("R6 att_tx enabled", att_tx_o, int'(k[1] & ~k[0]));
      check("R6 att_rx enabled", att_rx_o, int'(~(k[1] & ~k[0]) & 1'b1));
    end
    strobe_cycle(6'h00);
    for (int k = 0; k < 4; k++) begin
      rx_act = k[1]; tx_act = k[0];
      #1;
      check("R6 att off", {att_rx_o, att_tx_o}, 0);
    end

    // R9: power-down with done high
    @(negedge clk);
    pwr_ni = 1'b0;
    repeat (4) @(negedge clk);
    s0 = n_start;
    mode_in = 6'h3F;
    cyc_strobe = 1'b0;
    repeat (4) @(negedge clk);
    cyc_strobe = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 no start in power-down", n_start - s0, 0);
    check("R9 mode unchanged in power-down", mode_out, 0);
    check("R9 done held high", cyc_done_o, 1);
    pwr_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R9: power-down mid-cycle freezes done low
    mode_in = 6'h15;
    cyc_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 start before power-down", proc_start_o, 1);
    pwr_ni = 1'b0;
    cyc_strobe = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 done held low mid-cycle", cyc_done_o, 0);
    pwr_ni = 1'b1;
    repeat (PROC_N + 4) @(negedge clk);
    check("R8 cycle completes after resume", cyc_done_o, 1);

    // R8: reset forces done low
    rst_ni = 1'b0;
    #1;
    check("R8 done low in reset", cyc_done_o, 0);
    check("R5 mode low in reset", mode_out, 0);
    repeat (3) @(negedge clk);
    check("R8 done stays low in reset", cyc_done_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule